// File: doc/BRIEF.md
# Event Readiness Timeout Controller

This block decides when an event can be assembled from several input channels. Each channel raises a one-cycle ready strobe once its processed data for the current event is available. The first enabled strobe opens a channel window. Any enabled channel still silent when the window closes is marked as timed out. The fragment builder then emits only a sub-header and a sub-status word with the timeout bit set for that channel. A strobe from that channel later in the same event has no effect.

The trigger type of an event arrives over a broadcast path with no fixed latency. Once every enabled channel is resolved (ready or timed out), a second window starts. If no trigger type has been captured when that window closes, a programmable default is used and a flag records the substitution. When both conditions are met, the block raises an event-go strobe. It holds that strobe, the timeout flags and the trigger type steady until the fragment builder acknowledges. An event-counter-reset pulse discards all partial or pending event state, including a trigger type that has already been captured. Both window lengths are programmable in clock cycles, and a length of zero disables that timeout.

Top module: `evrt_ctrl`

## Requirements
- R1: The first ready strobe on an enabled channel (`ch_rdy_i[i]` high while `ch_en_i[i]` is 1) starts the channel window. Timeout flags are never raised before some channel has been latched ready.
- R2: With channel limit L>0 and the first strobe sampled at edge E, strobes sampled at edges up to and including E+L are accepted. Each enabled channel still not ready after edge E+L has its bit set in `ch_tmo_o`. A channel that is latched ready is never flagged.
- R3: A channel whose `ch_en_i` bit is 0 is never waited for and never flagged. A strobe on it does not start an event.
- R4: A ready strobe from a channel that has already timed out in the current event changes neither `ch_tmo_o` nor `evt_go_o`.
- R5: The trigger-type window starts at the first edge after all enabled channels are resolved. With trigger limit T>0 and no trigger type captured, edge T of that window loads `tt_default_i` into `ttype_o` and sets `ttype_dflt_o`.
- R6: The first `ttype_vld_i` of an event is captured, and `ttype_dflt_o` stays 0. Further valid pulses before the acknowledge are ignored, including those after a default was applied.
- R7: `evt_go_o` rises one cycle after the cycle in which all enabled channels are resolved and the trigger type is resolved. While it is high and unacknowledged, `ch_tmo_o`, `ttype_o` and `ttype_dflt_o` hold, and ready strobes and trigger-type pulses are ignored.
- R8: `go_ack_i` sampled while `evt_go_o` is high clears the event. In the next cycle `evt_go_o`, `ch_tmo_o` and `ttype_dflt_o` are 0, and a new event may begin.
- R9: An `ecr_i` pulse clears all event state on the next edge: ready and timeout flags, both window counters, any captured or defaulted trigger type (`ttype_o` returns to 0), and a pending `evt_go_o`.
- R10: A channel limit of 0 means channels are waited for without end. A trigger limit of 0 means the trigger type is waited for without end.
- R11: After reset `evt_go_o`, `ch_tmo_o`, `ttype_o` and `ttype_dflt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_rdy_i | input | NUM_CH | Per-channel ready strobes |
| ch_en_i | input | NUM_CH | Channel enable mask, 1 = expected |
| ttype_vld_i | input | 1 | Trigger-type valid pulse |
| ttype_i | input | TT_W | Trigger-type value |
| ecr_i | input | 1 | Event-counter-reset pulse |
| ch_limit_i | input | CNT_W | Channel window length in cycles, 0 = no timeout |
| tt_limit_i | input | CNT_W | Trigger-type window length in cycles, 0 = no timeout |
| tt_default_i | input | TT_W | Trigger type used on trigger-type timeout |
| go_ack_i | input | 1 | Acknowledge from the fragment builder |
| ch_tmo_o | output | NUM_CH | Per-channel timeout flags |
| ttype_o | output | TT_W | Resolved trigger type |
| ttype_dflt_o | output | 1 | Trigger type came from the default |
| evt_go_o | output | 1 | Event ready for assembly, held until acknowledged |

## Verification
Some properties are checked on every cycle. A timeout flag never coexists with a latched ready bit for the same channel, and no flag appears before the event has started. A defaulted trigger type equals the default input from the loading edge. The go strobe and its outputs stay frozen until acknowledged, and both acknowledge and counter reset wipe the event. Other behaviour depends on cycle counts and stimulus history, and only the bench scenarios show it. This covers the exact window edges, strobes accepted on the closing edge, disabled channels and late strobes being ignored, first-wins trigger capture, zero limits waiting without end, and a reset discarding a captured trigger type so that the next event falls back to the default.

// File: rtl/evrt_pkg.sv
// Shared types for the event readiness timeout controller.
// Assumes: imported by every module of the block.
package evrt_pkg;

    // Phase of the current event, derived from the registered state.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,   // no enabled channel ready yet
        PH_GATHER = 2'd1,   // channel window running
        PH_TTWAIT = 2'd2,   // channels resolved, trigger type pending
        PH_ISSUE  = 2'd3    // go strobe raised, waiting for acknowledge
    } evt_phase_e;

endpackage

// File: rtl/evrt_window_timer.sv
// Programmable window counter.
// Counts cycles while run_i is high. expire_o is high in the cycle in which
// the window reaches its limit (limit-1 full counts already elapsed).
// A limit of zero never expires.
// Assumes: run_i stays high from its start until the window is left, and
// clr_i returns the counter to zero between uses.
module evrt_window_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             lim_on;

    // Window closes when the count reaches limit-1 while running.
    always_comb begin
        lim_on   = (limit_i != '0);
        expire_o = run_i && lim_on && (cnt_q == limit_i - CNT_W'(1));
    end

    // Elapsed-cycle counter, frozen once expired or when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (run_i && !expire_o) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/evrt_chan_tracker.sv
// Per-channel ready and timeout flags for one event.
// A channel latches ready on its strobe when enabled, not timed out and not
// on hold. On window expiry, every enabled channel neither latched nor
// strobing in that cycle is flagged as timed out.
// Assumes: clr_i wipes the event; hold_i freezes the flags.
module evrt_chan_tracker #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              hold_i,
    input  logic [NUM_CH-1:0] en_i,
    input  logic [NUM_CH-1:0] rdy_i,
    input  logic              expire_i,
    output logic [NUM_CH-1:0] rdy_q_o,
    output logic [NUM_CH-1:0] tmo_q_o
);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic take;

        // Strobe counts only for an enabled, still-open channel.
        always_comb begin
            take = rdy_i[gi] && en_i[gi] && !tmo_q_o[gi] && !hold_i;
        end

        // Ready flag for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                rdy_q_o[gi] <= 1'b0;
            end else if (take) begin
                rdy_q_o[gi] <= 1'b1;
            end
        end

        // Timeout flag for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                tmo_q_o[gi] <= 1'b0;
            end else if (expire_i && en_i[gi] && !rdy_q_o[gi] && !take) begin
                tmo_q_o[gi] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/evrt_ttype_latch.sv
// Trigger-type capture with default substitution.
// The first valid pulse of an event is captured. If the window expires first,
// the default value is loaded and marked. A valid pulse in the expiry cycle
// wins over the default.
// Assumes: clr_i wipes the event; hold_i blocks capture while issuing.
module evrt_ttype_latch #(
    parameter int TT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            hold_i,
    input  logic            vld_i,
    input  logic [TT_W-1:0] val_i,
    input  logic            expire_i,
    input  logic [TT_W-1:0] default_i,
    output logic            res_o,
    output logic [TT_W-1:0] val_o,
    output logic            dflt_o
);

    logic cap;

    // Capture allowed only while unresolved and not issuing.
    always_comb begin
        cap = vld_i && !res_o && !hold_i;
    end

    // Resolved value, flag and default marker.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            res_o  <= 1'b0;
            val_o  <= '0;
            dflt_o <= 1'b0;
        end else if (cap) begin
            res_o  <= 1'b1;
            val_o  <= val_i;
        end else if (expire_i && !res_o) begin
            res_o  <= 1'b1;
            val_o  <= default_i;
            dflt_o <= 1'b1;
        end
    end

endmodule

// File: rtl/evrt_ctrl.sv
// Event readiness timeout controller (top).
// Opens a channel window on the first enabled ready strobe and flags channels
// that miss it. It then waits a second window for the trigger type and falls
// back to a default. It raises a held go strobe until acknowledged. An
// event-counter-reset pulse clears everything.
// Assumes: ready and trigger-type inputs are single-cycle pulses in clk domain.
module evrt_ctrl #(
    parameter int NUM_CH = 4,
    parameter int TT_W   = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_rdy_i,
    input  logic [NUM_CH-1:0] ch_en_i,
    input  logic              ttype_vld_i,
    input  logic [TT_W-1:0]   ttype_i,
    input  logic              ecr_i,
    input  logic [CNT_W-1:0]  ch_limit_i,
    input  logic [CNT_W-1:0]  tt_limit_i,
    input  logic [TT_W-1:0]   tt_default_i,
    input  logic              go_ack_i,
    output logic [NUM_CH-1:0] ch_tmo_o,
    output logic [TT_W-1:0]   ttype_o,
    output logic              ttype_dflt_o,
    output logic              evt_go_o
);
    import evrt_pkg::*;

    logic [NUM_CH-1:0] rdy_q;
    logic [NUM_CH-1:0] tmo_q;
    logic              tt_res;
    logic              go_q;
    logic              started;
    logic              all_done;
    logic              clr_evt;
    logic              hold;
    logic              ch_run;
    logic              tt_run;
    logic              ch_expire;
    logic              tt_expire;
    evt_phase_e        phase;

    // Event progress and phase from registered state.
    always_comb begin
        started  = |rdy_q;
        all_done = started && (&(rdy_q | tmo_q | ~ch_en_i));
        if (go_q)          phase = PH_ISSUE;
        else if (all_done) phase = PH_TTWAIT;
        else if (started)  phase = PH_GATHER;
        else               phase = PH_IDLE;
        clr_evt = ecr_i || (go_q && go_ack_i);
        hold    = (phase == PH_ISSUE);
        ch_run  = (phase == PH_GATHER);
        tt_run  = (phase == PH_TTWAIT) && !tt_res;
    end

    evrt_window_timer #(.CNT_W(CNT_W)) u_ch_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_evt),
        .run_i    (ch_run),
        .limit_i  (ch_limit_i),
        .expire_o (ch_expire)
    );

    evrt_window_timer #(.CNT_W(CNT_W)) u_tt_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_evt),
        .run_i    (tt_run),
        .limit_i  (tt_limit_i),
        .expire_o (tt_expire)
    );

    evrt_chan_tracker #(.NUM_CH(NUM_CH)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_evt),
        .hold_i   (hold),
        .en_i     (ch_en_i),
        .rdy_i    (ch_rdy_i),
        .expire_i (ch_expire),
        .rdy_q_o  (rdy_q),
        .tmo_q_o  (tmo_q)
    );

    evrt_ttype_latch #(.TT_W(TT_W)) u_tt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_evt),
        .hold_i    (hold),
        .vld_i     (ttype_vld_i),
        .val_i     (ttype_i),
        .expire_i  (tt_expire),
        .default_i (tt_default_i),
        .res_o     (tt_res),
        .val_o     (ttype_o),
        .dflt_o    (ttype_dflt_o)
    );

    // Go strobe: raised once everything is resolved, held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_evt) begin
            go_q <= 1'b0;
        end else if (!go_q && all_done && tt_res) begin
            go_q <= 1'b1;
        end
    end

    // Output drive.
    always_comb begin
        ch_tmo_o = tmo_q;
        evt_go_o = go_q;
    end

endmodule

// File: rtl/evrt_ctrl_chk.sv
// Property checker for evrt_ctrl, attached by bind.
// Assumes: rdy_q is the top's latched per-channel ready state.
module evrt_ctrl_chk #(
    parameter int NUM_CH = 4,
    parameter int TT_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ecr_i,
    input logic              go_ack_i,
    input logic [TT_W-1:0]   tt_default_i,
    input logic [NUM_CH-1:0] ch_tmo_o,
    input logic [TT_W-1:0]   ttype_o,
    input logic              ttype_dflt_o,
    input logic              evt_go_o,
    input logic [NUM_CH-1:0] rdy_q
);

    // R1: no timeout flag before the event has started
    a_r1_flag_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_tmo_o) |-> (|rdy_q));

    // R2: a latched ready channel is never flagged
    a_r2_ready_not_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_tmo_o & rdy_q) == '0);

    // R5: the defaulted trigger type equals the default at the loading edge
    a_r5_default_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ttype_dflt_o) |-> (ttype_o == $past(tt_default_i)));

    // R7: go and its outputs hold until acknowledged
    a_r7_go_held: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_go_o && !go_ack_i && !ecr_i) |=>
        (evt_go_o && $stable(ch_tmo_o) && $stable(ttype_o) && $stable(ttype_dflt_o)));

    // R8: acknowledge ends the event
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_go_o && go_ack_i) |=> (!evt_go_o && ch_tmo_o == '0 && !ttype_dflt_o));

    // R9: counter reset wipes the event
    a_r9_ecr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ecr_i |=> (!evt_go_o && ch_tmo_o == '0 && !ttype_dflt_o && ttype_o == '0));

endmodule

bind evrt_ctrl evrt_ctrl_chk #(.NUM_CH(NUM_CH), .TT_W(TT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ecr_i        (ecr_i),
    .go_ack_i     (go_ack_i),
    .tt_default_i (tt_default_i),
    .ch_tmo_o     (ch_tmo_o),
    .ttype_o      (ttype_o),
    .ttype_dflt_o (ttype_dflt_o),
    .evt_go_o     (evt_go_o),
    .rdy_q        (rdy_q)
);

// File: tb/evrt_ctrl_tb_top.sv
// Directed bench for evrt_ctrl: one task per scenario, each checking itself.
module evrt_ctrl_tb_top;

    localparam int NCH = 4;
    localparam int TW  = 8;
    localparam int CW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ch_rdy = '0;
    logic [NCH-1:0] ch_en = '1;
    logic           tt_vld = 1'b0;
    logic [TW-1:0]  tt_val = '0;
    logic           ecr = 1'b0;
    logic [CW-1:0]  ch_lim = '0;
    logic [CW-1:0]  tt_lim = '0;
    logic [TW-1:0]  tt_def = '0;
    logic           ack = 1'b0;
    logic [NCH-1:0] tmo;
    logic [TW-1:0]  ttype;
    logic           dflt;
    logic           go;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    evrt_ctrl #(.NUM_CH(NCH), .TT_W(TW), .CNT_W(CW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_rdy_i     (ch_rdy),
        .ch_en_i      (ch_en),
        .ttype_vld_i  (tt_vld),
        .ttype_i      (tt_val),
        .ecr_i        (ecr),
        .ch_limit_i   (ch_lim),
        .tt_limit_i   (tt_lim),
        .tt_default_i (tt_def),
        .go_ack_i     (ack),
        .ch_tmo_o     (tmo),
        .ttype_o      (ttype),
        .ttype_dflt_o (dflt),
        .evt_go_o     (go)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_rdy(input logic [NCH-1:0] m);
        ch_rdy = m;
        @(negedge clk);
        ch_rdy = '0;
    endtask

    task automatic pulse_tt(input logic [TW-1:0] v);
        tt_vld = 1'b1;
        tt_val = v;
        @(negedge clk);
        tt_vld = 1'b0;
    endtask

    task automatic pulse_ecr();
        ecr = 1'b1;
        @(negedge clk);
        ecr = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R8 go after ack", go, 0);
        check("R8 tmo after ack", tmo, 0);
        check("R8 dflt after ack", dflt, 0);
    endtask

    task automatic t_reset();
        check("R11 go", go, 0);
        check("R11 tmo", tmo, 0);
        check("R11 ttype", ttype, 0);
        check("R11 dflt", dflt, 0);
    endtask

    task automatic t_all_arrive();
        ch_en = 4'hF; ch_lim = 5; tt_lim = 5;
        pulse_tt(8'h22);
        pulse_tt(8'h33);
        pulse_rdy(4'h1);
        tick();
        pulse_rdy(4'hE);
        check("R7 go not before resolve", go, 0);
        tick();
        check("R7 go rises", go, 1);
        check("R1 no tmo when all arrive", tmo, 0);
        check("R6 first trigger type wins", ttype, 8'h22);
        check("R6 no default", dflt, 0);
        pulse_rdy(4'hF);
        pulse_tt(8'h44);
        check("R7 go held", go, 1);
        check("R7 ttype held", ttype, 8'h22);
        do_ack();
    endtask

    task automatic t_timeout();
        ch_en = 4'hF; ch_lim = 4; tt_lim = 0;
        pulse_rdy(4'h1);
        pulse_rdy(4'h2);
        tick();
        tick();
        check("R2 no tmo before window end", tmo, 0);
        tick();
        check("R2 missing channels flagged", tmo, 4'hC);
        check("R10 go waits for trigger type", go, 0);
        pulse_rdy(4'h4);
        check("R4 late strobe leaves tmo", tmo, 4'hC);
        check("R4 late strobe leaves go", go, 0);
        repeat (20) tick();
        check("R10 zero trigger limit never defaults", dflt, 0);
        check("R10 go still waiting", go, 0);
        pulse_tt(8'h5A);
        check("R7 go one cycle after resolve", go, 0);
        tick();
        check("R7 go after trigger type", go, 1);
        check("R4 flags kept at go", tmo, 4'hC);
        check("R6 captured value", ttype, 8'h5A);
        do_ack();
    endtask

    task automatic t_boundary();
        ch_en = 4'hF; ch_lim = 3; tt_lim = 5;
        pulse_tt(8'h01);
        pulse_rdy(4'h1);
        tick();
        tick();
        pulse_rdy(4'hE);
        check("R2 strobe on closing edge accepted", tmo, 0);
        tick();
        check("R2 go after boundary", go, 1);
        check("R2 still no tmo", tmo, 0);
        do_ack();
    endtask

    task automatic t_default();
        ch_en = 4'hF; ch_lim = 5; tt_lim = 3; tt_def = 8'hA5;
        pulse_rdy(4'hF);
        tick();
        tick();
        check("R5 no default early", dflt, 0);
        check("R5 no go early", go, 0);
        tick();
        check("R5 default flag", dflt, 1);
        check("R5 default value", ttype, 8'hA5);
        check("R7 go not yet", go, 0);
        tick();
        check("R7 go after default", go, 1);
        pulse_tt(8'h11);
        check("R6 late trigger type ignored", ttype, 8'hA5);
        do_ack();
    endtask

    task automatic t_mask();
        ch_en = 4'h5; ch_lim = 2; tt_lim = 0;
        pulse_tt(8'h03);
        pulse_rdy(4'h2);
        repeat (5) tick();
        check("R3 disabled strobe starts nothing", go, 0);
        check("R3 disabled strobe no tmo", tmo, 0);
        pulse_rdy(4'h1);
        tick();
        tick();
        check("R3 only enabled missing flagged", tmo, 4'h4);
        tick();
        check("R3 go with partial timeout", go, 1);
        do_ack();
        pulse_tt(8'h03);
        pulse_rdy(4'h5);
        check("R3 go not same cycle", go, 0);
        tick();
        check("R3 enabled set complete", go, 1);
        check("R3 no flags", tmo, 0);
        do_ack();
    endtask

    task automatic t_chlimit0();
        ch_en = 4'hF; ch_lim = 0; tt_lim = 0;
        pulse_tt(8'h09);
        pulse_rdy(4'h1);
        repeat (40) tick();
        check("R10 zero channel limit never flags", tmo, 0);
        check("R10 go waits for channels", go, 0);
        pulse_rdy(4'hE);
        tick();
        check("R10 go once complete", go, 1);
        do_ack();
    endtask

    task automatic t_ecr();
        ch_en = 4'hF; ch_lim = 3; tt_lim = 2; tt_def = 8'h66;
        pulse_tt(8'h77);
        pulse_rdy(4'h1);
        tick();
        pulse_ecr();
        check("R9 go cleared", go, 0);
        check("R9 ttype cleared", ttype, 0);
        repeat (5) tick();
        check("R9 channel window cleared", tmo, 0);
        pulse_rdy(4'hF);
        tick();
        tick();
        check("R9 old trigger type discarded", dflt, 1);
        check("R9 default used after reset", ttype, 8'h66);
        tick();
        check("R9 go for new event", go, 1);
        pulse_ecr();
        check("R9 pending go dropped", go, 0);
        check("R9 dflt dropped", dflt, 0);
        check("R9 ttype dropped", ttype, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_all_arrive();
        t_timeout();
        t_boundary();
        t_default();
        t_mask();
        t_chlimit0();
        t_ecr();
        repeat (2) tick();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule